// File: doc/BRIEF.md
# Double-Rate Pattern-Lookup Pre-Emphasis Backend

This block produces the digital code for a transmit equalizer at each symbol. It does not multiply taps. It looks the code up in a programmable table that is indexed by the recent bit history. The serial stream enters two bits per clock, an even symbol and an odd symbol, with the even symbol first in time. A 3-bit history register keeps the latest stream bits across clock boundaries. Each symbol's address therefore holds that symbol's bit and the three bits before it, which gives 16 possible patterns.

There are two separate tables, one for each half-rate phase, and each holds 16 sign-magnitude words. Because the two tables are independent, software can scale one phase against the other to correct duty-cycle imbalance. It can also fold predistortion for driver compression into the stored values. Software loads entries through a plain address/data/write-enable port, and the contents stay static while the link runs. The looked-up codes are registered. During the high half of the clock the output carries the even code, and during the low half it carries the odd code, which forms one double-rate code stream for the downstream segment decoder.

Top module: `ddr_pattern_eq`

## Requirements
- R1: A synchronous active-low reset clears the bit history and every entry of both tables. From the first rising edge with reset low, until an entry is written, code_out is 0 in both halves of the clock.
- R2: The even symbol's table address has bit 3 = odd bit from two cycles earlier, bit 2 = even bit of the previous cycle, bit 1 = odd bit of the previous cycle, and bit 0 = the current even bit.
- R3: The odd symbol's table address has bit 3 = even bit of the previous cycle, bit 2 = odd bit of the previous cycle, bit 1 = the current even bit, and bit 0 = the current odd bit.
- R4: wr_phase = 0 writes the even table and wr_phase = 1 writes the odd table. A write to one table never changes the codes produced by the other.
- R5: A table word has the sign in bit 6 and the magnitude in bits 5:0. The block delivers it unchanged, including a negative zero (7'h40) and full-scale positive (7'h3F).
- R6: Bits presented before rising edge n produce the even code during the high half after edge n and the odd code during the following low half.
- R7: A write sampled at edge n does not affect the lookup made at edge n. Every lookup from edge n+1 onward uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-pair clock; its level also selects the output phase |
| rst_n | input | 1 | Synchronous active-low reset |
| din_even | input | 1 | Earlier stream bit of the current pair |
| din_odd | input | 1 | Later stream bit of the current pair |
| wr_en | input | 1 | Table write strobe |
| wr_phase | input | 1 | Target table: 0 even, 1 odd |
| wr_addr | input | 4 | Pattern address of the entry written |
| wr_code | input | 7 | Sign-magnitude word written |
| code_out | output | 7 | Even code while clk is high, odd code while clk is low |

## Verification
A wrong history bit sends a lookup to a neighbouring pattern. Every table is loaded with a distinct word per address, so such an error shows as a wrong code in the very next half-cycle of the affected phase. A missing cross-cycle carry shows only on patterns whose older bits differ from the newer ones, which is why random data is mixed with directed walking patterns. Table corruption, crosstalk between the two tables, or write-timing slips appear at the first lookup of the touched entry. The directed cases force that lookup one cycle after the write.

// File: rtl/eq_pkg.sv
// Package: shared defaults and phase indices for the pattern-lookup equalizer.
// Assumes a two-symbol-per-clock stream with the even symbol earlier in time.
package eq_pkg;
    localparam int EQ_TAPS  = 4;  // symbols spanned by one pattern address
    localparam int EQ_MAG_W = 6;  // magnitude bits of a table word
    localparam int PH_EVEN  = 0;  // index of the even-phase table
    localparam int PH_ODD   = 1;  // index of the odd-phase table
    localparam int PHASES   = 2;  // tables, one per half-rate phase
endpackage

// File: rtl/eq_history.sv
// Module: eq_history
// Keeps the most recent TAPS-1 stream bits and forms the pattern address for
// both symbols of the current pair. Assumes TAPS >= 2 and the even bit earlier
// than the odd bit. The address MSB is the oldest bit.
module eq_history #(
    parameter int TAPS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din_even,
    input  logic            din_odd,
    output logic [TAPS-1:0] addr_even,
    output logic [TAPS-1:0] addr_odd
);
    localparam int HIST_W = TAPS - 1;

    logic [HIST_W-1:0] hist_q;
    logic [TAPS:0]     window;

    // Purpose: line up stored history and the new pair, oldest bit first.
    always_comb begin
        window    = {hist_q, din_even, din_odd};
        addr_even = window[TAPS:1];
        addr_odd  = window[TAPS-1:0];
    end

    // Purpose: shift the newest bits of the stream into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= window[HIST_W-1:0];
    end
endmodule

// File: rtl/eq_pattern_table.sv
// Module: eq_pattern_table
// One writable pattern table with a registered read. A write at an edge is
// seen by lookups from the next edge on. Reset clears every entry and the
// registered code.
module eq_pattern_table #(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] code_q
);
    localparam int ENTRIES = 1 << ADDR_W;

    logic [CODE_W-1:0] mem_q [ENTRIES];

    // Purpose: clear the table on reset, else store the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_code;
        end
    end

    // Purpose: register the word picked by the current pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= mem_q[rd_addr];
    end
endmodule

// File: rtl/eq_phase_mux.sv
// Module: eq_phase_mux
// Merges the two registered phase codes into one double-rate stream.
// Assumes both inputs come from registers on the rising edge, so each half
// of the clock shows a settled word.
module eq_phase_mux #(
    parameter int CODE_W = 7
) (
    input  logic              phase_hi,
    input  logic [CODE_W-1:0] code_even,
    input  logic [CODE_W-1:0] code_odd,
    output logic [CODE_W-1:0] code_out
);
    // Purpose: even code on the high half, odd code on the low half.
    always_comb begin
        code_out = phase_hi ? code_even : code_odd;
    end
endmodule

// File: rtl/ddr_pattern_eq.sv
// Module: ddr_pattern_eq (top)
// Transmit pre-emphasis backend: the bit history addresses one of two
// independent per-phase tables, and the registered codes are muxed by clock
// level. Assumes table contents are loaded before traffic and kept static.
module ddr_pattern_eq
    import eq_pkg::*;
#(
    parameter int TAPS  = EQ_TAPS,
    parameter int MAG_W = EQ_MAG_W,
    localparam int ADDR_W = TAPS,
    localparam int CODE_W = MAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_even,
    input  logic              din_odd,
    input  logic              wr_en,
    input  logic              wr_phase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_out
);
    logic [ADDR_W-1:0] addr_even;
    logic [ADDR_W-1:0] addr_odd;
    logic [ADDR_W-1:0] rd_addr [PHASES];
    logic [CODE_W-1:0] code_ph [PHASES];
    logic [CODE_W-1:0] code_even;
    logic [CODE_W-1:0] code_odd;

    eq_history #(.TAPS(TAPS)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_even  (din_even),
        .din_odd   (din_odd),
        .addr_even (addr_even),
        .addr_odd  (addr_odd)
    );

    // Purpose: route each phase's pattern address to its table.
    always_comb begin
        rd_addr[PH_EVEN] = addr_even;
        rd_addr[PH_ODD]  = addr_odd;
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        eq_pattern_table #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_tab (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_phase == 1'(p))),
            .wr_addr (wr_addr),
            .wr_code (wr_code),
            .rd_addr (rd_addr[p]),
            .code_q  (code_ph[p])
        );
    end

    // Purpose: name the per-phase registered codes.
    always_comb begin
        code_even = code_ph[PH_EVEN];
        code_odd  = code_ph[PH_ODD];
    end

    eq_phase_mux #(.CODE_W(CODE_W)) u_mux (
        .phase_hi  (clk),
        .code_even (code_even),
        .code_odd  (code_odd),
        .code_out  (code_out)
    );
endmodule

// File: rtl/eq_checker.sv
// Module: eq_checker
// Temporal checks on the equalizer backend, bound into the top module.
module eq_checker #(
    parameter int TAPS   = 4,
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din_even,
    input logic              din_odd,
    input logic              wr_en,
    input logic              wr_phase,
    input logic [TAPS-1:0]   wr_addr,
    input logic [CODE_W-1:0] wr_code,
    input logic [TAPS-1:0]   addr_even,
    input logic [TAPS-1:0]   addr_odd,
    input logic [CODE_W-1:0] code_even,
    input logic [CODE_W-1:0] code_odd
);
    // R1: both registered codes are zero on leaving reset
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code_even == '0) && (code_odd == '0));

    // R2: previous pair sits in the middle bits of the even address
    assert_even_history_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> addr_even[2:1] == $past({din_even, din_odd}));

    // R3: previous pair sits in the upper bits of the odd address
    assert_odd_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> addr_odd[3:2] == $past({din_even, din_odd}));

    // R7: an even-table write is seen by the next lookup of that entry
    assert_even_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_phase) ##1 (addr_even == $past(wr_addr))
        |=> code_even == $past(wr_code, 2));

    // R7: an odd-table write is seen by the next lookup of that entry
    assert_odd_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_phase) ##1 (addr_odd == $past(wr_addr))
        |=> code_odd == $past(wr_code, 2));
endmodule

bind ddr_pattern_eq eq_checker #(.TAPS(TAPS), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_even  (din_even),
    .din_odd   (din_odd),
    .wr_en     (wr_en),
    .wr_phase  (wr_phase),
    .wr_addr   (wr_addr),
    .wr_code   (wr_code),
    .addr_even (addr_even),
    .addr_odd  (addr_odd),
    .code_even (code_even),
    .code_odd  (code_odd)
);

// File: tb/ddr_pattern_eq_tb.sv
// Bench: directed corner cases plus seeded random traffic, scored against a
// bench-side model of the history and both tables.
module ddr_pattern_eq_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       din_even, din_odd, wr_en, wr_phase;
    logic [3:0] wr_addr;
    logic [6:0] wr_code;
    logic [6:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [6:0] m_tab [2][16];
    logic [2:0] m_hist;

    ddr_pattern_eq u_dut (
        .clk(clk), .rst_n(rst_n), .din_even(din_even), .din_odd(din_odd),
        .wr_en(wr_en), .wr_phase(wr_phase), .wr_addr(wr_addr),
        .wr_code(wr_code), .code_out(code_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [3:0] even_addr(logic [2:0] h, logic e);
        return {h, e};
    endfunction

    function automatic logic [3:0] odd_addr(logic [2:0] h, logic e, logic o);
        return {h[1:0], e, o};
    endfunction

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: code_out=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, predict, then sample high and low halves.
    task automatic cycle(logic e, logic o, logic we, logic ph, logic [3:0] a,
                         logic [6:0] d, string tag_e, string tag_o);
        logic [6:0] exp_e, exp_o;
        din_even = e; din_odd = o; wr_en = we; wr_phase = ph;
        wr_addr = a; wr_code = d;
        if (!rst_n) begin
            exp_e = '0; exp_o = '0;
            m_hist = '0;
            for (int i = 0; i < 16; i++) begin
                m_tab[0][i] = '0; m_tab[1][i] = '0;
            end
        end else begin
            exp_e  = m_tab[0][even_addr(m_hist, e)];
            exp_o  = m_tab[1][odd_addr(m_hist, e, o)];
            if (we) m_tab[ph][a] = d;
            m_hist = {m_hist[0], e, o};
        end
        @(posedge clk);
        #(CLK_P/4);
        check(tag_e, code_out, exp_e);
        #(CLK_P/2);
        check(tag_o, code_out, exp_o);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        din_even = 0; din_odd = 0; wr_en = 0; wr_phase = 0; wr_addr = 0; wr_code = 0;
        m_hist = '0;
        #2;
        // R1: reset holds zero codes
        for (int i = 0; i < 3; i++) cycle(1, 1, 0, 0, 0, 0, "R1", "R1");
        rst_n = 1'b1;
        // R1: empty tables give zero for any data
        for (int i = 0; i < 4; i++)
            cycle(1'($urandom), 1'($urandom), 0, 0, 0, 0, "R1", "R1");
        // Load distinct words into both tables (R4 phase select)
        for (int a = 0; a < 16; a++)
            cycle(0, 0, 1, 0, 4'(a), 7'(a * 7 + 5), "R4", "R4");
        for (int a = 0; a < 16; a++)
            cycle(0, 0, 1, 1, 4'(a), 7'(8'h40 | 8'(a * 3 + 2)), "R4", "R4");
        // R6: walking pattern, even on high half, odd on low half
        cycle(1, 0, 0, 0, 0, 0, "R6", "R6");
        cycle(0, 1, 0, 0, 0, 0, "R6", "R6");
        cycle(1, 1, 0, 0, 0, 0, "R2", "R3");
        cycle(0, 0, 0, 0, 0, 0, "R2", "R3");
        cycle(0, 1, 0, 0, 0, 0, "R2", "R3");
        cycle(0, 0, 0, 0, 0, 0, "R2", "R3");
        cycle(0, 0, 0, 0, 0, 0, "R2", "R3");
        // R7: write even[0] while addr 0 is read; the old word shows first
        cycle(0, 0, 1, 0, 4'd0, 7'h2A, "R7", "R7");
        cycle(0, 0, 0, 0, 0, 0, "R7", "R7");
        // R4: odd write leaves even output alone, and the reverse
        cycle(0, 0, 1, 1, 4'd0, 7'h15, "R4", "R7");
        cycle(0, 0, 1, 0, 4'd0, 7'h33, "R4", "R4");
        cycle(0, 0, 0, 0, 0, 0, "R4", "R4");
        // R5: sign/magnitude words pass unchanged
        cycle(0, 0, 1, 0, 4'd0, 7'h40, "R5", "R5");
        cycle(0, 0, 1, 1, 4'd0, 7'h3F, "R5", "R5");
        cycle(0, 0, 1, 0, 4'd0, 7'h7F, "R5", "R5");
        cycle(0, 0, 0, 0, 0, 0, "R5", "R5");
        // Random traffic with occasional table rewrites
        for (int i = 0; i < 600; i++)
            cycle(1'($urandom), 1'($urandom), ($urandom % 10) < 3, 1'($urandom),
                  4'($urandom), 7'($urandom), "R2", "R3");
        // R1: reset mid-run clears loaded tables
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++)
            cycle(1'($urandom), 1'($urandom), 0, 0, 0, 0, "R1", "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++)
            cycle(1'($urandom), 1'($urandom), 0, 0, 0, 0, "R1", "R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule